// File: doc/BRIEF.md
# Programmable Automaton Runtime Monitor

This block watches a running system for violations of a safety property. Each monitoring step consumes one character: a vector of Boolean propositions that the host writes into a valuation register. The property is supplied at run time as a non-deterministic finite automaton whose accepting states stand for a violation. The monitor keeps the set of automaton states that are reachable on the prefix seen so far. Each valuation write replaces that set with the union of the successor masks of all active states.

Successor masks live in two lookup banks. A bank is chosen by the top bit of the state index. Within it, the entry is addressed by the remaining state bits followed by the valuation. A step visits the active states in ascending index order, one per cycle. The read data of each bank passes through a registered buffer before it is ORed into an accumulator, and the accumulated set is loaded at the end of the walk. A programmable failure mask marks the states that mean a violation. The violation flag stays set until the host restarts the monitor, and the restart reloads a programmable initial mask. With the default 6 propositions and 16 states, each bank is 512 entries of 16 bits, which is 1 kB. A step-down configuration with fewer propositions fits the same structure.

Top module: `nfa_monitor`

## Requirements
- R1: After reset the state set equals INIT_RESET, and violation, busy and overrun are all 0.
- R2: The host writes with host_we=1, and host_sel selects the target: 0 = valuation (host_wdata[NPROP-1:0]), 1 = restart, 2 = initial mask, 3 = failure mask, 4 = table entry. While idle, only a valuation write or a restart changes the state set.
- R3: A valuation write accepted while idle performs exactly one step. The new state set is the OR, over every active state s, of the table entry at {s, valuation}.
- R4: busy rises on the edge that accepts the valuation. With k>0 active states it stays high for k+2 cycles, and with an empty set for 1 cycle. The state set does not change while busy is high.
- R5: When a step loads a set that shares any state with the failure mask, violation is set. It stays set through later steps until a restart.
- R6: A restart write, accepted at any time, aborts a walk in progress. It loads the state set from the initial mask and clears violation, overrun and busy on the next edge.
- R7: A valuation write while busy is ignored: the step in progress completes with its original valuation. It sets overrun, which stays set until a restart.
- R8: A table write is ignored while busy. A table write accepted while idle stores host_wdata at table index host_addr = {state, valuation}. Bit i of an entry, and of every mask, stands for state i.
- R9: For the automaton "red (valuation bit 0) and green (bit 1) are never on together", violation rises on exactly the first step whose valuation has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Register select for the write |
| host_addr | input | $clog2(NSTATE)+NPROP | Table index {state, valuation} |
| host_wdata | input | NSTATE | Write data: mask, table entry or valuation |
| state_set | output | NSTATE | Current set of reachable states |
| violation | output | 1 | Sticky violation flag |
| busy | output | 1 | A step walk is in progress |
| overrun | output | 1 | Sticky flag for a valuation dropped while busy |

## Verification
The bench builds the monitor with 2 propositions and 4 states. This makes the whole transition table 16 entries, so every entry can be programmed and modelled in the bench. Every three-character word over the four valuations runs against the red/green automaton. A denser computed table then drives union sets of every size, including the empty set, which covers all walk lengths from 0 to 4 states. Overrun, ignored table writes and a mid-walk restart are checked with all four states active, which gives the longest walk.

// File: rtl/nfa_monitor_pkg.sv
package nfa_monitor_pkg;
  typedef enum logic [2:0] {
    SEL_VAL     = 3'd0,
    SEL_RESTART = 3'd1,
    SEL_INIT    = 3'd2,
    SEL_FAIL    = 3'd3,
    SEL_TABLE   = 3'd4
  } host_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;
endpackage

// File: rtl/mon_lut_bank.sv
module mon_lut_bank #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Registered read port acts as the read buffer.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mon_pick_lowest.sv
module mon_pick_lowest #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |mask;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nfa_monitor.sv
module nfa_monitor
  import nfa_monitor_pkg::*;
#(
  parameter int unsigned NPROP  = 6,
  parameter int unsigned NSTATE = 16,
  parameter logic [NSTATE-1:0] INIT_RESET = 1,
  parameter logic [NSTATE-1:0] FAIL_RESET = 0,
  localparam int unsigned SW  = $clog2(NSTATE),
  localparam int unsigned AW  = SW + NPROP,
  localparam int unsigned BAW = AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [NSTATE-1:0] host_wdata,
  output logic [NSTATE-1:0] state_set,
  output logic              violation,
  output logic              busy,
  output logic              overrun
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  walk_state_e       fsm_q, fsm_n;
  logic [NSTATE-1:0] set_q, set_n, init_q, init_n, fail_q, fail_n;
  logic [NSTATE-1:0] pend_q, pend_n, acc_q, acc_n;
  logic [NPROP-1:0]  val_q, val_n;
  logic              rvld_q, rvld_n, bank_q, bank_n;
  logic              viol_q, viol_n, ovr_q, ovr_n;

  logic              wr_val, wr_rst, wr_tab;
  logic [SW-1:0]     pick_idx;
  logic              pick_any, issue;
  logic [NSTATE-1:0] pick_bit, rd_mux;
  logic [NSTATE-1:0] bank_rd [2];

  assign wr_val = host_we && (host_sel == SEL_VAL);
  assign wr_rst = host_we && (host_sel == SEL_RESTART);
  assign wr_tab = host_we && (host_sel == SEL_TABLE) && (fsm_q == ST_IDLE);

  mon_pick_lowest #(.N(NSTATE)) u_pick (
    .mask (pend_q),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign issue    = (fsm_q == ST_WALK) && pick_any;
  assign pick_bit = {{(NSTATE-1){1'b0}}, 1'b1} << pick_idx;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    mon_lut_bank #(.AW(BAW), .DW(NSTATE)) u_bank (
      .clk   (clk),
      .we    (wr_tab && (host_addr[AW-1] == 1'(b))),
      .waddr (host_addr[BAW-1:0]),
      .wdata (host_wdata),
      .re    (issue && (pick_idx[SW-1] == 1'(b))),
      .raddr ({pick_idx[SW-2:0], val_q}),
      .rdata (bank_rd[b])
    );
  end

  assign rd_mux = bank_q ? bank_rd[1] : bank_rd[0];

  // next-state logic
  always_comb begin
    fsm_n  = fsm_q;
    set_n  = set_q;
    init_n = init_q;
    fail_n = fail_q;
    pend_n = pend_q;
    acc_n  = acc_q;
    val_n  = val_q;
    rvld_n = rvld_q;
    bank_n = bank_q;
    viol_n = viol_q;
    ovr_n  = ovr_q;

    if (host_we && (host_sel == SEL_INIT)) init_n = host_wdata;
    if (host_we && (host_sel == SEL_FAIL)) fail_n = host_wdata;

    unique case (fsm_q)
      ST_IDLE: begin
        if (wr_val) begin
          val_n  = host_wdata[NPROP-1:0];
          pend_n = set_q;
          acc_n  = '0;
          rvld_n = 1'b0;
          fsm_n  = ST_WALK;
        end
      end
      ST_WALK: begin
        if (wr_val) ovr_n = 1'b1;
        rvld_n = issue;
        if (issue) begin
          pend_n = pend_q & ~pick_bit;
          bank_n = pick_idx[SW-1];
        end
        if (rvld_q) acc_n = acc_q | rd_mux;
        if (!issue && !rvld_q) begin
          set_n = acc_q;
          if (|(acc_q & fail_q)) viol_n = 1'b1;
          fsm_n = ST_IDLE;
        end
      end
      default: fsm_n = ST_IDLE;
    endcase

    if (wr_rst) begin
      set_n  = init_q;
      viol_n = 1'b0;
      ovr_n  = 1'b0;
      rvld_n = 1'b0;
      fsm_n  = ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fsm_q  <= ST_IDLE;
      set_q  <= INIT_RESET;
      init_q <= INIT_RESET;
      fail_q <= FAIL_RESET;
      pend_q <= '0;
      acc_q  <= '0;
      val_q  <= '0;
      rvld_q <= 1'b0;
      bank_q <= 1'b0;
      viol_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      fsm_q  <= fsm_n;
      set_q  <= set_n;
      init_q <= init_n;
      fail_q <= fail_n;
      pend_q <= pend_n;
      acc_q  <= acc_n;
      val_q  <= val_n;
      rvld_q <= rvld_n;
      bank_q <= bank_n;
      viol_q <= viol_n;
      ovr_q  <= ovr_n;
    end
  end

  assign state_set = set_q;
  assign violation = viol_q;
  assign busy      = (fsm_q == ST_WALK);
  assign overrun   = ovr_q;
endmodule

// File: rtl/nfa_monitor_checker.sv
module nfa_monitor_checker #(
  parameter int unsigned NSTATE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [2:0]        host_sel,
  input logic [NSTATE-1:0] state_set,
  input logic              violation,
  input logic              busy,
  input logic              overrun,
  input logic [NSTATE-1:0] init_mask
);
  logic wr_val, wr_rst;
  assign wr_val = host_we && (host_sel == 3'd0);
  assign wr_rst = host_we && (host_sel == 3'd1);

  // R2: idle and no valuation or restart -> state set unchanged
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_val && !wr_rst) |=> $stable(state_set));

  // R4: state set frozen during a walk
  assert_hold_during_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_rst) |=> (busy -> $stable(state_set)));

  // R5: flag only rises at the end of a walk, then sticks
  assert_violation_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> $past(busy));
  assert_sticky_violation_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !wr_rst) |=> violation);

  // R6: restart reloads initial mask and clears flags
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (state_set == $past(init_mask)) && !violation && !overrun && !busy);

  // R7: valuation during walk raises overrun
  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_val) |=> overrun);
endmodule

bind nfa_monitor nfa_monitor_checker #(.NSTATE(NSTATE)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .state_set (state_set),
  .violation (violation),
  .busy      (busy),
  .overrun   (overrun),
  .init_mask (init_q)
);

// File: tb/tb_nfa_monitor.sv
module tb_nfa_monitor;
  localparam int NP = 2;
  localparam int NS = 4;
  localparam int AW = 4;

  logic          clk, rst_n, host_we;
  logic [2:0]    host_sel;
  logic [AW-1:0] host_addr;
  logic [NS-1:0] host_wdata;
  logic [NS-1:0] state_set;
  logic          violation, busy, overrun;

  int checks = 0;
  int errors = 0;
  logic [NS-1:0] tbl [16];
  logic [NS-1:0] mset, minit, mfail;
  logic          mviol;

  nfa_monitor #(.NPROP(NP), .NSTATE(NS), .INIT_RESET(4'b0001), .FAIL_RESET(4'b0000)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .state_set(state_set),
    .violation(violation), .busy(busy), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int sel, input int addr, input int data);
    @(negedge clk);
    host_we = 1'b1; host_sel = 3'(sel); host_addr = AW'(addr); host_wdata = NS'(data);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic restart();
    bus_write(1, 0, 0);
    mset = minit; mviol = 1'b0;
  endtask

  task automatic prog_table();
    for (int i = 0; i < 16; i++) bus_write(4, i, int'(tbl[i]));
  endtask

  function automatic logic [NS-1:0] model_next(input logic [NS-1:0] cur, input int v);
    logic [NS-1:0] r = '0;
    for (int s = 0; s < NS; s++) if (cur[s]) r |= tbl[s*4 + v];
    return r;
  endfunction

  task automatic do_step(input int v, input string req);
    int k, expb, cnt;
    k = $countones(mset);
    expb = (k == 0) ? 1 : k + 2;
    bus_write(0, 0, v);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    check("R4 busy length", cnt, expb);
    mset = model_next(mset, v);
    if ((mset & mfail) != 0) mviol = 1'b1;
    check({"R3 state set ", req}, int'(state_set), int'(mset));
    check({"R5 violation ", req}, int'(violation), int'(mviol));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic seen;
    int cnt;
    logic [NS-1:0] held;
    host_we = 1'b0; host_sel = '0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 state set", int'(state_set), 1);
    check("R1 violation", int'(violation), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 overrun", int'(overrun), 0);

    // R9: red=bit0, green=bit1; state1 is the failure state
    for (int s = 0; s < NS; s++)
      for (int v = 0; v < 4; v++)
        tbl[s*4+v] = (s == 0) ? ((v == 3) ? 4'b0011 : 4'b0001) : (s == 1) ? 4'b0010 : 4'b0000;
    prog_table();
    minit = 4'b0001; mfail = 4'b0010;
    bus_write(3, 0, 2);
    check("R2 fail mask write leaves set", int'(state_set), 1);
    for (int w = 0; w < 64; w++) begin
      restart();
      seen = 1'b0;
      for (int p = 0; p < 3; p++) begin
        int v = (w >> (2*p)) & 3;
        do_step(v, "R9 sweep");
        if (v == 3) seen = 1'b1;
        check("R9 red and green flag", int'(violation), int'(seen));
      end
    end

    // R3/R5: dense table, union sets of all sizes
    for (int i = 0; i < 16; i++) tbl[i] = NS'(((i * 7 + 3) ^ (i >> 1)) & 15);
    tbl[9] = 4'b0000; tbl[13] = 4'b0000;
    prog_table();
    minit = 4'b0101; mfail = 4'b1000;
    bus_write(2, 0, 5);
    bus_write(3, 0, 8);
    restart();
    check("R6 restart loads init", int'(state_set), 5);
    for (int j = 0; j < 40; j++) do_step((j * 3 + 1) % 4, "R3 union");
    // empty set
    minit = 4'b0000;
    bus_write(2, 0, 0);
    restart();
    do_step(2, "R4 empty");

    // R7 and R8: all states active, longest walk
    minit = 4'b1111;
    bus_write(2, 0, 15);
    restart();
    bus_write(0, 0, 1);
    bus_write(0, 0, 2);
    held = tbl[0*4+3];
    bus_write(4, 3, int'(~held));
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    mset = model_next(mset, 1);
    if ((mset & mfail) != 0) mviol = 1'b1;
    check("R7 step used first valuation", int'(state_set), int'(mset));
    check("R7 overrun set", int'(overrun), 1);
    do_step(0, "R7 after overrun");
    check("R7 overrun sticky", int'(overrun), 1);
    restart();
    mset = 4'b0001;
    bus_write(2, 0, 1);
    minit = 4'b0001;
    restart();
    do_step(3, "R8 table unchanged");

    // R8: write while idle takes effect
    bus_write(4, 3, 4'b0100);
    tbl[3] = 4'b0100;
    restart();
    do_step(3, "R8 idle write");

    // R6: restart mid-walk
    minit = 4'b1111;
    bus_write(2, 0, 15);
    restart();
    bus_write(0, 0, 0);
    bus_write(0, 0, 1);
    check("R7 overrun before restart", int'(overrun), 1);
    bus_write(1, 0, 0);
    check("R6 state after abort", int'(state_set), 15);
    check("R6 busy cleared", int'(busy), 0);
    check("R6 overrun cleared", int'(overrun), 0);
    check("R6 violation cleared", int'(violation), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule